// File: doc/BRIEF.md
# Memory-Mapped BCD Real-Time Clock

This block is a calendar clock that occupies the highest sixteen byte addresses of a larger address space. It keeps seconds, minutes, hours, weekday, date, month and a two-digit year, all in packed BCD. A pulse on the one-hertz tick input advances the time by one second. The increment carries through minutes, hours and days, and then through month lengths and leap years into the year.

A small alarm compares the seconds, minutes, hours and date against programmable values. Each of these fields can be excluded from the comparison by its own mask bit. A match raises a sticky flag, which reading the flags register clears. A control register can stop the clock and holds a calibration sign and magnitude for software. A sticky oscillator-fail flag tells software that the time may be stale. The flag is set at reset and whenever the clock is stopped, and software clears it after setting the time.

Access goes through a synchronous byte port. Writes take effect at the clock edge. Read data is registered and appears in the cycle after the read request.

Top module: `bcd_rtc_regfile`

## Requirements
- R1: Only addresses whose upper ADDR_W-4 bits are all ones reach the block, with the register at each low-nibble offset as follows. Offset 15 is year and offset 14 is month. Offsets 13, 12, 11, 10 and 9 are date, weekday, hour, minute and second. Offset 8 is control. Offsets 7, 6, 5 and 4 are the alarm second, minute, hour and date. Offset 3 is flags, and offsets 0–2 read 0x00. Writes outside the window change nothing, and reads outside it return 0x00.
- R2: After reset the registers hold year 0x00, month 0x01, date 0x01, weekday 0x01, time 00:00:00, control 0x00 and all alarms 0x00. Flags read 0x02, and alarm_irq is low.
- R3: Unused bits always read 0. Month keeps bits 4:0, date and hour keep bits 5:0, second and minute keep bits 6:0, and weekday keeps bits 2:0.
- R4: In the control register, bit 7 = 1 stops the clock and bit 7 = 0 lets it run. Bit 6 always reads 0. Bit 5 (calibration sign) and bits 4:0 (calibration magnitude) are stored and read back unchanged.
- R5: Each accepted tick adds one second in BCD. Seconds and minutes wrap from 59 to 00, and hours wrap from 23 to 00. A day rollover advances the date and the weekday, and the weekday wraps from 7 to 1.
- R6: Each month has its own last date: 30 for months 04, 06, 09 and 11, 31 for the other months, and 29 or 28 for month 02. February has 29 days when the year value is divisible by 4. After the last date, the date becomes 01 and the month advances. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R7: While control bit 7 is 1, ticks are ignored and the time does not change.
- R8: If a tick arrives in the same cycle as a write to any time register (offsets 9–15), the tick is dropped and the written value stands. Read data appears on rd_data in the cycle after rd_en.
- R9: Each alarm register uses bit 7 as its mask. When the mask is 1, that field always matches. When it is 0, the low bits must equal the corresponding time field. On an accepted tick, the alarm flag (flags bit 0, also driven on alarm_irq) is set when all four fields match the time that the tick produces.
- R10: A read of the flags register returns the value the flags had before the read, then clears the alarm flag. If an alarm match occurs in the same cycle, the flag stays set. Ticks, writes and reads of other registers never clear it.
- R11: The oscillator-fail flag (flags bit 1) is set at reset and when a write changes control bit 7 from 0 to 1. A flags write with bit 1 = 0 clears it, and a write with bit 1 = 1 leaves it unchanged. The control register is never altered by this flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second that advances the time |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| alarm_irq | output | 1 | Level copy of the sticky alarm flag |

## Verification
The bench builds the block with ADDR_W = 8, so the whole address space is 256 bytes. A sweep therefore writes every address outside the window and reads every one of them back. Rather than jumping the clock, the bench walks the time field by field: two full minutes of seconds, every hour boundary, and the last day of each month across eight consecutive years. The expected values come from plain integer arithmetic, which covers every month length and both February cases. The alarm, mask, stop and flag cases are driven as same-cycle collisions where the ordering matters.

// File: rtl/rtc_bcd_pkg.sv
package rtc_bcd_pkg;

    localparam int BYTE_W   = 8;
    localparam int WIN_BITS = 4;
    localparam int N_ALARM  = 4;

    typedef struct packed {
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] weekday;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] minute;
        logic [BYTE_W-1:0] second;
    } rtc_time_t;

    // register offsets inside the 16-byte window
    localparam logic [WIN_BITS-1:0] OFS_YEAR  = 4'hF;
    localparam logic [WIN_BITS-1:0] OFS_MONTH = 4'hE;
    localparam logic [WIN_BITS-1:0] OFS_DATE  = 4'hD;
    localparam logic [WIN_BITS-1:0] OFS_WDAY  = 4'hC;
    localparam logic [WIN_BITS-1:0] OFS_HOUR  = 4'hB;
    localparam logic [WIN_BITS-1:0] OFS_MIN   = 4'hA;
    localparam logic [WIN_BITS-1:0] OFS_SEC   = 4'h9;
    localparam logic [WIN_BITS-1:0] OFS_CTRL  = 4'h8;
    localparam logic [WIN_BITS-1:0] OFS_ASEC  = 4'h7;
    localparam logic [WIN_BITS-1:0] OFS_AMIN  = 4'h6;
    localparam logic [WIN_BITS-1:0] OFS_AHOUR = 4'h5;
    localparam logic [WIN_BITS-1:0] OFS_ADATE = 4'h4;
    localparam logic [WIN_BITS-1:0] OFS_FLAGS = 4'h3;

    // storable bits per register
    localparam logic [BYTE_W-1:0] MSK_YEAR  = 8'hFF;
    localparam logic [BYTE_W-1:0] MSK_MONTH = 8'h1F;
    localparam logic [BYTE_W-1:0] MSK_DATE  = 8'h3F;
    localparam logic [BYTE_W-1:0] MSK_WDAY  = 8'h07;
    localparam logic [BYTE_W-1:0] MSK_HOUR  = 8'h3F;
    localparam logic [BYTE_W-1:0] MSK_MS    = 8'h7F;
    localparam logic [BYTE_W-1:0] MSK_CTRL  = 8'hBF;
    localparam logic [N_ALARM-1:0][BYTE_W-1:0] MSK_ALARM = {8'hBF, 8'hBF, 8'hFF, 8'hFF};

    localparam int CTRL_STOP_BIT = 7;
    localparam int ALARM_MASK_BIT = 7;

    localparam rtc_time_t TIME_AT_RESET = '{
        year: 8'h00, month: 8'h01, date: 8'h01, weekday: 8'h01,
        hour: 8'h00, minute: 8'h00, second: 8'h00
    };

    // one BCD step: {carry, next}; at or beyond the limit wraps to lo
    function automatic logic [BYTE_W:0] bcd_step(input logic [BYTE_W-1:0] v,
                                                 input logic [BYTE_W-1:0] lim,
                                                 input logic [BYTE_W-1:0] lo);
        if (v >= lim)
            return {1'b1, lo};
        else if (v[3:0] == 4'h9)
            return {1'b0, v[7:4] + 4'h1, 4'h0};
        else
            return {1'b0, v[7:4], v[3:0] + 4'h1};
    endfunction

    function automatic logic leap_year(input logic [BYTE_W-1:0] y);
        logic [6:0] bin;
        bin = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
        return (bin[1:0] == 2'b00);
    endfunction

    function automatic logic [BYTE_W-1:0] last_date(input logic [BYTE_W-1:0] m,
                                                    input logic [BYTE_W-1:0] y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_time_advance.sv
module rtc_time_advance
    import rtc_bcd_pkg::*;
(
    input  rtc_time_t cur,
    output rtc_time_t nxt
);
    logic [BYTE_W:0] s_st, m_st, h_st, d_st, mo_st, y_st;
    logic            roll_min, roll_hour, roll_day, roll_mon, roll_year;

    always_comb begin
        s_st  = bcd_step(cur.second, 8'h59, 8'h00);
        m_st  = bcd_step(cur.minute, 8'h59, 8'h00);
        h_st  = bcd_step(cur.hour,   8'h23, 8'h00);
        d_st  = bcd_step(cur.date,   last_date(cur.month, cur.year), 8'h01);
        mo_st = bcd_step(cur.month,  8'h12, 8'h01);
        y_st  = bcd_step(cur.year,   8'h99, 8'h00);

        roll_min  = s_st[BYTE_W];
        roll_hour = roll_min  & m_st[BYTE_W];
        roll_day  = roll_hour & h_st[BYTE_W];
        roll_mon  = roll_day  & d_st[BYTE_W];
        roll_year = roll_mon  & mo_st[BYTE_W];

        nxt        = cur;
        nxt.second = s_st[BYTE_W-1:0];
        if (roll_min)  nxt.minute = m_st[BYTE_W-1:0];
        if (roll_hour) nxt.hour   = h_st[BYTE_W-1:0];
        if (roll_day) begin
            nxt.date    = d_st[BYTE_W-1:0];
            nxt.weekday = (cur.weekday >= 8'h07) ? 8'h01 : cur.weekday + 8'h01;
        end
        if (roll_mon)  nxt.month = mo_st[BYTE_W-1:0];
        if (roll_year) nxt.year  = y_st[BYTE_W-1:0];
    end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_bcd_pkg::*;
#(
    parameter int N_FIELDS = N_ALARM
)(
    input  logic [N_FIELDS-1:0][BYTE_W-1:0] alarm,
    input  logic [N_FIELDS-1:0][BYTE_W-1:0] now,
    output logic                            hit
);
    logic [N_FIELDS-1:0] fld_ok;

    for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
        assign fld_ok[i] = alarm[i][ALARM_MASK_BIT]
                         | (alarm[i][ALARM_MASK_BIT-1:0] == now[i][ALARM_MASK_BIT-1:0]);
    end

    assign hit = &fld_ok;
endmodule

// File: rtl/bcd_rtc_regfile.sv
module bcd_rtc_regfile
    import rtc_bcd_pkg::*;
#(
    parameter int ADDR_W = 20
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    output logic              alarm_irq
);
    localparam int HI_W = ADDR_W - WIN_BITS;

    rtc_time_t                         time_q, time_nxt;
    logic [BYTE_W-1:0]                 ctrl_q;
    logic [N_ALARM-1:0][BYTE_W-1:0]    alarm_q;
    logic [N_ALARM-1:0][BYTE_W-1:0]    alarm_now;
    logic                              alarm_flag, osc_fail;
    logic                              in_win, wr_hit, rd_hit, time_wr, advance, match;
    logic [WIN_BITS-1:0]               ofs;
    logic [BYTE_W-1:0]                 rd_mux;

    assign ofs     = addr[WIN_BITS-1:0];
    assign in_win  = (addr[ADDR_W-1:WIN_BITS] == {HI_W{1'b1}});
    assign wr_hit  = wr_en & in_win;
    assign rd_hit  = rd_en & in_win;
    assign time_wr = wr_hit & (ofs >= OFS_SEC);
    assign advance = tick_1hz & ~ctrl_q[CTRL_STOP_BIT] & ~time_wr;

    rtc_time_advance u_adv (
        .cur (time_q),
        .nxt (time_nxt)
    );

    assign alarm_now = {time_nxt.date, time_nxt.hour, time_nxt.minute, time_nxt.second};

    rtc_alarm_match #(.N_FIELDS(N_ALARM)) u_alm (
        .alarm (alarm_q),
        .now   (alarm_now),
        .hit   (match)
    );

    always_comb begin
        case (ofs)
            OFS_YEAR:  rd_mux = time_q.year;
            OFS_MONTH: rd_mux = time_q.month;
            OFS_DATE:  rd_mux = time_q.date;
            OFS_WDAY:  rd_mux = time_q.weekday;
            OFS_HOUR:  rd_mux = time_q.hour;
            OFS_MIN:   rd_mux = time_q.minute;
            OFS_SEC:   rd_mux = time_q.second;
            OFS_CTRL:  rd_mux = ctrl_q;
            OFS_ASEC:  rd_mux = alarm_q[0];
            OFS_AMIN:  rd_mux = alarm_q[1];
            OFS_AHOUR: rd_mux = alarm_q[2];
            OFS_ADATE: rd_mux = alarm_q[3];
            OFS_FLAGS: rd_mux = {6'b0, osc_fail, alarm_flag};
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q     <= TIME_AT_RESET;
            ctrl_q     <= '0;
            alarm_q    <= '0;
            alarm_flag <= 1'b0;
            osc_fail   <= 1'b1;
            rd_data    <= '0;
        end else begin
            if (rd_en)
                rd_data <= rd_hit ? rd_mux : '0;
            if (rd_hit && ofs == OFS_FLAGS)
                alarm_flag <= 1'b0;
            if (advance) begin
                time_q <= time_nxt;
                if (match)
                    alarm_flag <= 1'b1;
            end
            if (wr_hit) begin
                case (ofs)
                    OFS_YEAR:  time_q.year    <= wr_data & MSK_YEAR;
                    OFS_MONTH: time_q.month   <= wr_data & MSK_MONTH;
                    OFS_DATE:  time_q.date    <= wr_data & MSK_DATE;
                    OFS_WDAY:  time_q.weekday <= wr_data & MSK_WDAY;
                    OFS_HOUR:  time_q.hour    <= wr_data & MSK_HOUR;
                    OFS_MIN:   time_q.minute  <= wr_data & MSK_MS;
                    OFS_SEC:   time_q.second  <= wr_data & MSK_MS;
                    OFS_CTRL: begin
                        ctrl_q <= wr_data & MSK_CTRL;
                        if (wr_data[CTRL_STOP_BIT] && !ctrl_q[CTRL_STOP_BIT])
                            osc_fail <= 1'b1;
                    end
                    OFS_ASEC:  alarm_q[0] <= wr_data & MSK_ALARM[0];
                    OFS_AMIN:  alarm_q[1] <= wr_data & MSK_ALARM[1];
                    OFS_AHOUR: alarm_q[2] <= wr_data & MSK_ALARM[2];
                    OFS_ADATE: alarm_q[3] <= wr_data & MSK_ALARM[3];
                    OFS_FLAGS: osc_fail   <= osc_fail & wr_data[1];
                    default: ;
                endcase
            end
        end
    end

    assign alarm_irq = alarm_flag;
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker
    import rtc_bcd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              tick_1hz,
    input logic              wr_en,
    input logic              rd_en,
    input rtc_time_t         time_q,
    input logic [BYTE_W-1:0] ctrl_q,
    input logic              alarm_flag,
    input logic              osc_fail
);
    a_r3_month_upper_zero: assert property (@(posedge clk) disable iff (rst)
        time_q.month[7:5] == 3'b000);

    a_r4_ctrl_bit6_zero: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[6] == 1'b0);

    a_r7_stopped_holds: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[CTRL_STOP_BIT] && !wr_en |=> $stable(time_q));

    a_r5_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !tick_1hz && !wr_en |=> $stable(time_q));

    a_r9_alarm_needs_tick: assert property (@(posedge clk) disable iff (rst)
        !alarm_flag && !tick_1hz |=> !alarm_flag);

    a_r10_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
        alarm_flag && !rd_en |=> alarm_flag);

    a_r11_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        osc_fail && !wr_en |=> osc_fail);
endmodule

bind bcd_rtc_regfile rtc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_1hz   (tick_1hz),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .time_q     (time_q),
    .ctrl_q     (ctrl_q),
    .alarm_flag (alarm_flag),
    .osc_fail   (osc_fail)
);

// File: tb/tb_bcd_rtc_regfile.sv
`timescale 1ns/1ps
module tb_bcd_rtc_regfile;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick_1hz = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wr_data = '0;
    logic [7:0]    rd_data;
    logic          alarm_irq;

    int n_cmp = 0;
    int n_bad = 0;

    bcd_rtc_regfile #(.ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .alarm_irq(alarm_irq)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] ra(input int o);
        return 8'hF0 | 8'(o);
    endfunction

    function automatic logic [7:0] bcd(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int mdays(input int m, input int y);
        if (m == 2) return (y % 4 == 0) ? 29 : 28;
        if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
        return 31;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
    endtask

    task automatic set_time(input int y, input int mo, input int d, input int wd,
                            input int h, input int mi, input int s);
        wr(ra(15), bcd(y)); wr(ra(14), bcd(mo)); wr(ra(13), bcd(d));
        wr(ra(12), bcd(wd)); wr(ra(11), bcd(h)); wr(ra(10), bcd(mi));
        wr(ra(9), bcd(s));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] rst_exp [16];
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset contents of the whole window
        rst_exp = '{8'h00, 8'h00, 8'h00, 8'h02, 8'h00, 8'h00, 8'h00, 8'h00,
                    8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00};
        for (int o = 0; o < 16; o++) begin
            rd(ra(o), v);
            chk($sformatf("R2 reset offset %0d", o), v, rst_exp[o]);
        end
        chk("R2 reset alarm_irq", {7'b0, alarm_irq}, 8'h00);

        // R1: writes outside the window change nothing, reads there return 0
        set_time(42, 7, 15, 3, 10, 20, 30);
        for (int a = 0; a < 240; a++) wr(8'(a), 8'hFF);
        for (int a = 0; a < 240; a++) begin
            rd(8'(a), v);
            if (v !== 8'h00) chk($sformatf("R1 outside read %02h", a), v, 8'h00);
            else n_cmp++;
        end
        rd(ra(15), v); chk("R1 year kept", v, 8'h42);
        rd(ra(14), v); chk("R1 month kept", v, 8'h07);
        rd(ra(9), v);  chk("R1 second kept", v, 8'h30);
        for (int o = 0; o < 3; o++) begin
            wr(ra(o), 8'hFF); rd(ra(o), v);
            chk($sformatf("R1 reserved offset %0d", o), v, 8'h00);
        end

        // R3: unused bits read 0
        wr(ra(14), 8'hFF); rd(ra(14), v); chk("R3 month mask", v, 8'h1F);
        wr(ra(13), 8'hFF); rd(ra(13), v); chk("R3 date mask", v, 8'h3F);
        wr(ra(12), 8'hFF); rd(ra(12), v); chk("R3 weekday mask", v, 8'h07);
        wr(ra(11), 8'hFF); rd(ra(11), v); chk("R3 hour mask", v, 8'h3F);
        wr(ra(10), 8'hFF); rd(ra(10), v); chk("R3 minute mask", v, 8'h7F);

        // R5: two minutes of seconds into a day rollover
        wr(ra(7), 8'h80); wr(ra(6), 8'h80); wr(ra(5), 8'h80); wr(ra(4), 8'h80);
        set_time(0, 1, 1, 7, 23, 58, 0);
        for (int k = 1; k <= 120; k++) begin
            int tot;
            tick();
            tot = 58 * 60 + k;
            rd(ra(9), v);  chk($sformatf("R5 second tick %0d", k), v, bcd(tot % 60));
            rd(ra(10), v); chk($sformatf("R5 minute tick %0d", k), v, bcd((tot / 60) % 60));
        end
        rd(ra(11), v); chk("R5 hour wrap", v, 8'h00);
        rd(ra(13), v); chk("R5 date after day roll", v, 8'h02);
        rd(ra(12), v); chk("R5 weekday 7 to 1", v, 8'h01);
        for (int h = 0; h < 24; h++) begin
            set_time(5, 3, 10, 2, h, 59, 59);
            tick();
            rd(ra(11), v); chk($sformatf("R5 hour from %0d", h), v, bcd((h + 1) % 24));
        end

        // R6: last date of each month, eight years
        for (int y = 0; y < 8; y++) begin
            for (int m = 1; m <= 12; m++) begin
                int last;
                last = mdays(m, y);
                set_time(y, m, last - 1, 1, 23, 59, 59);
                tick();
                rd(ra(13), v); chk($sformatf("R6 day before end y%0d m%0d", y, m), v, bcd(last));
                wr(ra(11), 8'h23); wr(ra(10), 8'h59); wr(ra(9), 8'h59);
                tick();
                rd(ra(13), v); chk($sformatf("R6 date wrap y%0d m%0d", y, m), v, 8'h01);
                rd(ra(14), v); chk($sformatf("R6 month y%0d m%0d", y, m), v, bcd(m == 12 ? 1 : m + 1));
                rd(ra(15), v); chk($sformatf("R6 year y%0d m%0d", y, m), v, bcd(m == 12 ? y + 1 : y));
            end
        end
        set_time(99, 12, 31, 4, 23, 59, 59);
        tick();
        rd(ra(15), v); chk("R6 year 99 wrap", v, 8'h00);
        rd(ra(14), v); chk("R6 month 12 wrap", v, 8'h01);

        // R8: tick colliding with a time write is dropped
        set_time(10, 5, 5, 5, 5, 5, 5);
        @(negedge clk);
        tick_1hz = 1'b1; wr_en = 1'b1; addr = ra(9); wr_data = 8'h30;
        @(negedge clk);
        tick_1hz = 1'b0; wr_en = 1'b0;
        rd(ra(9), v); chk("R8 write beats tick", v, 8'h30);

        // R4, R7, R11: stop bit, control fields and fail flag
        wr(ra(3), 8'h00);
        rd(ra(3), v); chk("R11 fail cleared by write 0", v & 8'h02, 8'h00);
        wr(ra(8), 8'h3F); rd(ra(8), v); chk("R4 sign and magnitude stored", v, 8'h3F);
        rd(ra(3), v); chk("R11 no set while running", v & 8'h02, 8'h00);
        wr(ra(8), 8'hFF); rd(ra(8), v); chk("R4 bit6 reads 0", v, 8'hBF);
        rd(ra(3), v); chk("R11 set on stop 0->1", v & 8'h02, 8'h02);
        tick(); tick(); tick();
        rd(ra(9), v); chk("R7 stopped clock holds", v, 8'h30);
        rd(ra(8), v); chk("R11 control unaffected by flag", v, 8'hBF);
        wr(ra(3), 8'h00);
        wr(ra(8), 8'h80);
        rd(ra(3), v); chk("R11 no set when already stopped", v & 8'h02, 8'h00);
        wr(ra(3), 8'h02);
        rd(ra(3), v); chk("R11 writing 1 does not set", v & 8'h02, 8'h00);
        wr(ra(8), 8'h00);
        tick();
        rd(ra(9), v); chk("R4 runs when bit7 is 0", v, 8'h31);

        // R9: alarm on seconds only
        rd(ra(3), v);
        set_time(0, 1, 1, 1, 0, 0, 0);
        wr(ra(7), 8'h05); wr(ra(6), 8'h80); wr(ra(5), 8'h80); wr(ra(4), 8'h80);
        for (int k = 1; k <= 4; k++) tick();
        chk("R9 no alarm before match", {7'b0, alarm_irq}, 8'h00);
        tick();
        chk("R9 alarm on second match", {7'b0, alarm_irq}, 8'h01);
        // R10: read returns pre-clear value and clears
        rd(ra(3), v); chk("R10 read shows flag", v & 8'h01, 8'h01);
        chk("R10 cleared after read", {7'b0, alarm_irq}, 8'h00);
        // R9: hour unmasked and mismatching blocks the alarm
        wr(ra(5), 8'h01);
        set_time(0, 1, 1, 1, 0, 0, 0);
        for (int k = 1; k <= 5; k++) tick();
        chk("R9 unmasked hour blocks", {7'b0, alarm_irq}, 8'h00);
        set_time(0, 1, 1, 1, 1, 0, 0);
        for (int k = 1; k <= 5; k++) tick();
        chk("R9 hour and second match", {7'b0, alarm_irq}, 8'h01);
        rd(ra(3), v);
        // R9: date alarm compares the time after rollover
        wr(ra(7), 8'h80); wr(ra(5), 8'h80); wr(ra(4), 8'h02);
        set_time(0, 1, 1, 1, 23, 59, 59);
        tick();
        chk("R9 date match after rollover", {7'b0, alarm_irq}, 8'h01);
        // R10: flag survives writes and other reads
        wr(ra(9), 8'h10); rd(ra(9), v);
        chk("R10 sticky over other access", {7'b0, alarm_irq}, 8'h01);
        rd(ra(3), v);
        // R10: match and flags read in the same cycle, set wins
        wr(ra(4), 8'h80);
        @(negedge clk);
        tick_1hz = 1'b1; rd_en = 1'b1; addr = ra(3);
        @(negedge clk);
        tick_1hz = 1'b0; rd_en = 1'b0;
        chk("R10 read shows old value", rd_data & 8'h01, 8'h00);
        chk("R10 set wins over clear", {7'b0, alarm_irq}, 8'h01);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule